// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This unit sits beside the instruction fetch stage of a 32-bit core and handles one hardware loop without spending any instructions on the loop-back. It holds three 32-bit registers: the first address of the loop body, the address of the last instruction of the body, and the number of loop-backs still to take. Every fetch that presents a valid program counter is compared with the end address. If the two match and the count is non-zero, the unit raises a redirect strobe in that same cycle with the loop start as the target, and it lowers the count by one on the next clock edge.

Software can reach the three registers through a control-register port. A write to a register lands on the next clock edge, and a read returns the value held now. A dedicated setup path loads all three registers in one cycle from the setup instruction's own address, a 12-bit immediate and a source register value. This lets a single instruction arm a loop whose start directly follows it and whose end lies at a halfword offset from it.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, all three registers read as zero and no redirect is raised for any fetched address.
- R2: The registers sit at control addresses 0x7C0 (loop start), 0x7C1 (loop end) and 0x7C2 (loop count). A write takes effect on the next clock edge. A read returns the current value. A read of any other address returns zero, and a write to any other address changes none of the three registers.
- R3: When `fetch_valid` is high, `fetch_pc` equals the loop end and the count is non-zero, `redir_valid` is high in that same cycle and `redir_target` equals the loop start.
- R4: Each taken redirect lowers the count by exactly one on the next clock edge, unless a higher-priority load happens in that cycle.
- R5: With a count of zero, no redirect is raised even when the fetched address equals the loop end, and the count stays at zero.
- R6: With `fetch_valid` low, no redirect is raised and the count does not change.
- R7: A setup load sets the loop start to `setup_pc` + 4 and the loop end to `setup_pc` + (`setup_imm` zero-extended and multiplied by two). It sets the count to `setup_src`.
- R8: When a setup load and a taken redirect happen in the same cycle, the setup values are stored and the decrement is dropped.
- R9: Registers load with this priority: setup load first, then a control-register write, then the loop-back decrement.
- R10: A fetch whose address differs from the loop end raises no redirect and leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| redir_valid | output | 1 | Steer the next fetch to `redir_target` |
| redir_target | output | 32 | Loop start address |
| csr_we | input | 1 | Control-register write strobe |
| csr_addr | input | 12 | Control-register address for read and write |
| csr_wdata | input | 32 | Control-register write data |
| csr_rdata | output | 32 | Current value at `csr_addr` (combinational) |
| setup_valid | input | 1 | Setup instruction executes this cycle |
| setup_pc | input | 32 | Address of the setup instruction |
| setup_imm | input | 12 | Unsigned end offset in halfwords |
| setup_src | input | 32 | Source register value for the count |

## Verification
A stale or corrupted loop end shows up at once: fetches at the intended end address produce no strobe, and a strobe appears at some other address in the same cycle that address is fetched. A count that is off by one changes how many strobes a loop produces, so that error shows up at the last pass of the loop. A wrong count can also be read back through the control port on the cycle after the faulty update. A lost priority case, such as a decrement that beats a setup load, leaves a register value that differs from the loaded one. That value can be read on the very next cycle.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int XLEN      = 32;
  localparam int IMM_W     = 12;
  localparam int CSR_AW    = 12;
  localparam int NREG      = 3;
  localparam int IDX_START = 0;
  localparam int IDX_END   = 1;
  localparam int IDX_CNT   = 2;

  typedef logic [XLEN-1:0] word_t;

  // start of the body: the instruction right after the setup
  function automatic word_t loop_start_of(input word_t pc);
    return pc + word_t'(4);
  endfunction

  // end of the body: halfword offset, zero-extended before the add
  function automatic word_t loop_end_of(input word_t pc, input logic [IMM_W-1:0] imm);
    logic [IMM_W:0] off;
    off = {imm, 1'b0};
    return pc + word_t'(off);
  endfunction

  function automatic word_t dec_count(input word_t c);
    return c - word_t'(1);
  endfunction
endpackage

// File: rtl/hwloop_csr_dec.sv
module hwloop_csr_dec
  import hwloop_pkg::*;
#(
  parameter logic [CSR_AW-1:0] CSR_BASE = 12'h7C0
) (
  input  logic [CSR_AW-1:0]          addr,
  input  logic                       we,
  input  logic [NREG-1:0][XLEN-1:0]  regs_q,
  output logic [NREG-1:0]            wr_sel,
  output word_t                      rdata
);
  logic [NREG-1:0] hit;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i]    = (addr == CSR_BASE + CSR_AW'(i));
    assign wr_sel[i] = we & hit[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rdata = regs_q[i];
    end
  end
endmodule

// File: rtl/hwloop_state.sv
module hwloop_state
  import hwloop_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       setup_valid,
  input  logic [NREG-1:0][XLEN-1:0]  setup_vals,
  input  logic [NREG-1:0]            wr_sel,
  input  word_t                      wdata,
  input  logic                       take,
  output logic [NREG-1:0][XLEN-1:0]  regs_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit IS_CNT = (i == IDX_CNT);
    word_t r_q;
    logic  dec_en;

    assign dec_en = IS_CNT & take;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            r_q <= '0;
      else if (setup_valid)  r_q <= setup_vals[i];
      else if (wr_sel[i])    r_q <= wdata;
      else if (dec_en)       r_q <= dec_count(r_q);
    end

    assign regs_q[i] = r_q;
  end
endmodule

// File: rtl/hwloop_match.sv
module hwloop_match
  import hwloop_pkg::*;
(
  input  logic  fetch_valid,
  input  word_t fetch_pc,
  input  word_t loop_start,
  input  word_t loop_end,
  input  word_t loop_cnt,
  output logic  take,
  output word_t target
);
  logic at_end;
  logic armed;

  assign at_end = (fetch_pc == loop_end);
  assign armed  = (loop_cnt != '0);
  assign take   = fetch_valid & at_end & armed;
  assign target = loop_start;
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter logic [CSR_AW-1:0] CSR_BASE = 12'h7C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [XLEN-1:0]   fetch_pc,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_target,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              setup_valid,
  input  logic [XLEN-1:0]   setup_pc,
  input  logic [IMM_W-1:0]  setup_imm,
  input  logic [XLEN-1:0]   setup_src
);
  logic [NREG-1:0][XLEN-1:0] regs_q;
  logic [NREG-1:0][XLEN-1:0] setup_vals;
  logic [NREG-1:0]           wr_sel;
  logic                      loop_take;
  word_t                     start_q;
  word_t                     end_q;
  word_t                     cnt_q;

  assign start_q = regs_q[IDX_START];
  assign end_q   = regs_q[IDX_END];
  assign cnt_q   = regs_q[IDX_CNT];

  assign setup_vals[IDX_START] = loop_start_of(setup_pc);
  assign setup_vals[IDX_END]   = loop_end_of(setup_pc, setup_imm);
  assign setup_vals[IDX_CNT]   = setup_src;

  hwloop_csr_dec #(.CSR_BASE(CSR_BASE)) u_dec (
    .addr   (csr_addr),
    .we     (csr_we),
    .regs_q (regs_q),
    .wr_sel (wr_sel),
    .rdata  (csr_rdata)
  );

  hwloop_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_valid (setup_valid),
    .setup_vals  (setup_vals),
    .wr_sel      (wr_sel),
    .wdata       (csr_wdata),
    .take        (loop_take),
    .regs_q      (regs_q)
  );

  hwloop_match u_match (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .loop_start  (start_q),
    .loop_end    (end_q),
    .loop_cnt    (cnt_q),
    .take        (loop_take),
    .target      (redir_target)
  );

  assign redir_valid = loop_take;
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk
  import hwloop_pkg::*;
#(
  parameter logic [CSR_AW-1:0] CSR_BASE = 12'h7C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              redir_valid,
  input logic [XLEN-1:0]   redir_target,
  input logic              csr_we,
  input logic [CSR_AW-1:0] csr_addr,
  input logic              setup_valid,
  input logic [XLEN-1:0]   setup_pc,
  input logic [XLEN-1:0]   setup_src,
  input logic              loop_take,
  input logic [XLEN-1:0]   start_q,
  input logic [XLEN-1:0]   end_q,
  input logic [XLEN-1:0]   cnt_q
);
  logic cnt_written;
  assign cnt_written = csr_we && (csr_addr == CSR_BASE + CSR_AW'(IDX_CNT));

  // R3
  redir_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_target == start_q) && (cnt_q != '0) && fetch_valid);

  // R4
  dec_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_take && !setup_valid && !cnt_written) |=> (cnt_q == $past(cnt_q) - 1));

  // R5
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !redir_valid);

  // R7
  setup_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid |=> (start_q == $past(setup_pc) + 32'd4) && (cnt_q == $past(setup_src)));

  // R8
  setup_beats_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && loop_take) |=> (cnt_q == $past(setup_src)));

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_take && !setup_valid && !csr_we) |=> $stable(cnt_q) && $stable(start_q) && $stable(end_q));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.CSR_BASE(CSR_BASE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_valid  (fetch_valid),
  .redir_valid  (redir_valid),
  .redir_target (redir_target),
  .csr_we       (csr_we),
  .csr_addr     (csr_addr),
  .setup_valid  (setup_valid),
  .setup_pc     (setup_pc),
  .setup_src    (setup_src),
  .loop_take    (loop_take),
  .start_q      (start_q),
  .end_q        (end_q),
  .cnt_q        (cnt_q)
);

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        redir_valid;
  logic [31:0] redir_target;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        setup_valid = 1'b0;
  logic [31:0] setup_pc = '0;
  logic [11:0] setup_imm = '0;
  logic [31:0] setup_src = '0;

  always #4 clk = ~clk;

  hwloop_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .redir_valid(redir_valid), .redir_target(redir_target),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .setup_valid(setup_valid), .setup_pc(setup_pc), .setup_imm(setup_imm), .setup_src(setup_src)
  );

  typedef struct {
    logic        rv;
    logic [31:0] tgt;
    logic [31:0] rd;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference registers, written from the requirements
  logic [31:0] m_start = '0, m_end = '0, m_cnt = '0;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h7C0: return m_start;
      12'h7C1: return m_end;
      12'h7C2: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic fv, input logic [31:0] pc,
                      input logic cwe, input logic [11:0] ca, input logic [31:0] cwd,
                      input logic sv, input logic [31:0] spc, input logic [11:0] simm,
                      input logic [31:0] ssrc, input string req);
    exp_t e;
    logic hit;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc;
    csr_we = cwe; csr_addr = ca; csr_wdata = cwd;
    setup_valid = sv; setup_pc = spc; setup_imm = simm; setup_src = ssrc;
    hit = fv && (pc == m_end) && (m_cnt != 0);
    e.rv = hit; e.tgt = m_start; e.rd = m_read(ca); e.req = req;
    exp_q.push_back(e);
    if (sv) begin
      m_start = spc + 32'd4;
      m_end   = spc + {19'd0, simm, 1'b0};
      m_cnt   = ssrc;
    end else if (cwe && ca == 12'h7C0) m_start = cwd;
    else if (cwe && ca == 12'h7C1) m_end = cwd;
    else if (cwe && ca == 12'h7C2) m_cnt = cwd;
    else if (hit) m_cnt = m_cnt - 32'd1;
  endtask

  task automatic fetch(input logic [31:0] pc, input logic [11:0] ra, input string req);
    step(1'b1, pc, 1'b0, ra, 32'h0, 1'b0, 32'h0, 12'h0, 32'h0, req);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    step(1'b0, 32'h0, 1'b1, a, d, 1'b0, 32'h0, 12'h0, 32'h0, req);
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    step(1'b0, 32'h0, 1'b0, a, 32'h0, 1'b0, 32'h0, 12'h0, 32'h0, req);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "redir_valid", {31'd0, redir_valid}, {31'd0, e.rv});
        if (e.rv) check(e.req, "redir_target", redir_target, e.tgt);
        check(e.req, "csr_rdata", csr_rdata, e.rd);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(12'h7C0, "R1");
    rd(12'h7C1, "R1");
    rd(12'h7C2, "R1");
    fetch(32'h0, 12'h7C2, "R1");
    // R2: direct register access
    wr(12'h7C0, 32'h0000_0100, "R2");
    wr(12'h7C1, 32'h0000_0120, "R2");
    wr(12'h7C2, 32'd2, "R2");
    wr(12'h7C5, 32'hDEAD_BEEF, "R2");
    rd(12'h7C0, "R2");
    rd(12'h7C1, "R2");
    rd(12'h7C3, "R2");
    rd(12'h7C5, "R2");
    // R10: address mismatch
    fetch(32'h0000_011C, 12'h7C2, "R10");
    fetch(32'h0000_0124, 12'h7C2, "R10");
    // R6: no fetch presented
    step(1'b0, 32'h0000_0120, 1'b0, 12'h7C2, 32'h0, 1'b0, 32'h0, 12'h0, 32'h0, "R6");
    rd(12'h7C2, "R6");
    // R3 / R4: two loop-backs
    fetch(32'h0000_0120, 12'h7C2, "R3");
    fetch(32'h0000_0120, 12'h7C2, "R4");
    // R5: count exhausted
    fetch(32'h0000_0120, 12'h7C2, "R5");
    fetch(32'h0000_0120, 12'h7C2, "R5");
    // R7: setup with the largest immediate
    step(1'b0, 32'h0, 1'b0, 12'h7C0, 32'h0, 1'b1, 32'h0000_0200, 12'hFFF, 32'd5, "R7");
    rd(12'h7C0, "R7");
    rd(12'h7C1, "R7");
    rd(12'h7C2, "R7");
    fetch(32'h0000_21FE, 12'h7C2, "R7");
    // R8: setup and loop-back in the same cycle
    step(1'b1, 32'h0000_21FE, 1'b0, 12'h7C2, 32'h0, 1'b1, 32'h0000_0400, 12'h003, 32'd9, "R8");
    rd(12'h7C0, "R8");
    rd(12'h7C1, "R8");
    rd(12'h7C2, "R8");
    // R9: register write beats decrement
    step(1'b1, 32'h0000_0406, 1'b1, 12'h7C2, 32'd7, 1'b0, 32'h0, 12'h0, 32'h0, "R9");
    rd(12'h7C2, "R9");
    // R9: setup beats register write
    step(1'b0, 32'h0, 1'b1, 12'h7C2, 32'd3, 1'b1, 32'h0000_1000, 12'h010, 32'd1, "R9");
    rd(12'h7C2, "R9");
    rd(12'h7C1, "R9");
    fetch(32'h0000_1020, 12'h7C2, "R3");
    fetch(32'h0000_1020, 12'h7C2, "R5");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule